// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block turns single-beat requests from a synchronous port into correctly timed strobe sequences for a 2048-word by 8-bit asynchronous static RAM. A requester presents a valid flag, a write flag, an 11-bit word address and a byte of write data. It holds them until the controller signals ready on a rising clock edge. The controller then runs one complete memory cycle and raises a one-cycle done pulse. For a read, the captured byte is on the response data port in that same cycle.

On the memory side the controller drives active-low chip select, output enable and write strobe, plus the address bus. The bidirectional data bus is split into a driven value, a drive enable and a sampled input, so that pad cells can be added outside. A write is formed by the overlap of chip select and write strobe, and both rise together to end it. The write data is launched only after the write strobe is already low, and it stays driven for one cycle after the closing edge. A read holds chip select and output enable low with the write strobe high, and samples the bus once the access count has run out.

Every timing interval is a parameter counted in clock cycles: write pulse, data setup, access time, bus turnaround and minimum start-to-start period. A value of zero is treated as one. The controller holds further requests off until the current cycle, any turnaround and the minimum period have all elapsed.

Top module: `sram_cyc_ctl`

## Requirements
- R1: While reset is high, and in the first cycle after it, chip select, output enable and write strobe are all high, the data drive enable is low, done is low and ready is high.
- R2: A write request holds chip select and write strobe low together for 1+WD consecutive cycles, where WD = max(T_SD, T_PWE-1, 1). This count is at least T_PWE. Both strobes rise on the same edge, and the byte on the data output at that edge is stored at the request address. Done is high in the cycle after the strobes rise, which is the (2+WD)-th cycle after the accepting edge.
- R3: The data drive enable is low in the first cycle of each write strobe. It is high for at least max(T_SD,1) cycles immediately before the write-ending edge and in the one cycle after it. It is never high at any other time.
- R4: A read request holds chip select and output enable low, with the write strobe high, for max(T_AA,1) cycles. The bus is sampled at the edge that ends the last of these cycles. In the next cycle, which is the (max(T_AA,1)+1)-th cycle after the accepting edge, all strobes are high, done is high and the response data equals the addressed word.
- R5: Done is high for exactly one cycle per accepted request.
- R6: The data drive enable is never high while the memory is driving the bus (chip select low, output enable low, write strobe high). Output enable falls only after at least max(T_TURN,1) full cycles with the drive enable low.
- R7: Ready is low in the cycle after an accepting edge and while any cycle or turnaround is in progress. Two accepting edges are at least max(T_MIN_CYC,1) cycles apart. With back-to-back requests, the gap is exactly the larger of that minimum and the occupancy: max(T_AA,1)+2 for a read, or 3+WD+max(T_TURN,1) for a write.
- R8: The address bus does not change while chip select is low, and the lowest and highest addresses (0 and 2047) are written and read correctly.
- R9: An instance built with every timing parameter at zero behaves as if each were one. A write completes with done in the 3rd cycle after acceptance, a read completes with done in the 2nd cycle, and the data round-trips.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (11) | Word address of the request |
| req_wdata | input | DATA_W (8) | Byte to write |
| req_ready | output | 1 | Request is taken on a rising edge when valid and ready are both high |
| rsp_data | output | DATA_W (8) | Byte captured by the most recent read |
| rsp_done | output | 1 | One-cycle completion pulse |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_addr | output | ADDR_W (11) | Memory address bus |
| mem_dq_out | output | DATA_W (8) | Value for the data bus when driven |
| mem_dq_oe | output | 1 | Data bus drive enable, active high |
| mem_dq_in | input | DATA_W (8) | Sampled data bus |

## Verification
Two functions can meet in the same cycle: the completion of a write, with its done pulse, and a new request waiting at the port while the turnaround and minimum-period windows are still open. This overlap is provoked by issuing requests back to back, with each one presented in the cycle right after the previous done. The outcome is judged by the measured spacing between accepting edges against the larger of the minimum period and the occupancy. It is also judged by the count of driver-free cycles before the next output enable falls, and by a memory model in the bench that flags any cycle in which both sides drive the bus.

// File: rtl/sram_cyc_pkg.sv
package sram_cyc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACC,
        ST_RD_DONE,
        ST_WR_LEAD,
        ST_WR_DATA,
        ST_WR_END,
        ST_WR_TURN
    } cyc_state_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic dq_oe;
        logic done;
    } strobe_t;

    function automatic int at_least_one(input int v);
        return (v < 1) ? 1 : v;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int cnt_width(input int v);
        int w;
        w = $clog2(v + 1);
        return (w < 1) ? 1 : w;
    endfunction

endpackage

// File: rtl/sram_cyc_timer.sv
module sram_cyc_timer #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    output logic             expired
);
    logic [WIDTH-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/sram_cyc_pacer.sv
module sram_cyc_pacer
    import sram_cyc_pkg::*;
#(
    parameter int MIN_GAP = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic ok
);
    localparam int GAP = at_least_one(MIN_GAP);
    localparam int W   = cnt_width(GAP);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (start)
            cnt <= W'(GAP - 1);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign ok = (cnt == '0);
endmodule

// File: rtl/sram_cyc_ctl.sv
module sram_cyc_ctl
    import sram_cyc_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int DATA_W    = 8,
    parameter int T_PWE     = 3,
    parameter int T_SD      = 2,
    parameter int T_AA      = 3,
    parameter int T_TURN    = 2,
    parameter int T_MIN_CYC = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_done,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int PWE_C  = at_least_one(T_PWE);
    localparam int SD_C   = at_least_one(T_SD);
    localparam int AA_C   = at_least_one(T_AA);
    localparam int TURN_C = at_least_one(T_TURN);
    // driven part of the strobe: long enough for setup and for the pulse
    localparam int WD     = max2(SD_C, PWE_C - 1);
    localparam int CW     = cnt_width(max2(max2(AA_C, WD), TURN_C));

    cyc_state_e        state, state_nxt;
    logic              tmr_load, tmr_expired, accept, pace_ok;
    logic [CW-1:0]     tmr_val;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, rdata_q;
    strobe_t           strb;

    assign accept = req_valid && req_ready;

    sram_cyc_timer #(.WIDTH(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sram_cyc_pacer #(.MIN_GAP(T_MIN_CYC)) u_pacer (
        .clk   (clk),
        .rst   (rst),
        .start (accept),
        .ok    (pace_ok)
    );

    always_comb begin
        state_nxt = state;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        unique case (state)
            ST_IDLE: if (accept) begin
                state_nxt = req_write ? ST_WR_LEAD : ST_RD_ACC;
                tmr_load  = !req_write;
                tmr_val   = CW'(AA_C - 1);
            end
            ST_RD_ACC:  if (tmr_expired) state_nxt = ST_RD_DONE;
            ST_RD_DONE: state_nxt = ST_IDLE;
            ST_WR_LEAD: begin
                state_nxt = ST_WR_DATA;
                tmr_load  = 1'b1;
                tmr_val   = CW'(WD - 1);
            end
            ST_WR_DATA: if (tmr_expired) state_nxt = ST_WR_END;
            ST_WR_END: begin
                state_nxt = ST_WR_TURN;
                tmr_load  = 1'b1;
                tmr_val   = CW'(TURN_C - 1);
            end
            ST_WR_TURN: if (tmr_expired) state_nxt = ST_IDLE;
            default:    state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            state <= state_nxt;
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (state == ST_RD_ACC && tmr_expired)
                rdata_q <= mem_dq_in;
        end
    end

    // strobe decode: {ce_n, oe_n, we_n, dq_oe, done}
    always_comb begin
        unique case (state)
            ST_RD_ACC:  strb = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
            ST_RD_DONE: strb = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1};
            ST_WR_LEAD: strb = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0};
            ST_WR_DATA: strb = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
            ST_WR_END:  strb = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1};
            default:    strb = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0};
        endcase
    end

    assign mem_ce_n   = strb.ce_n;
    assign mem_oe_n   = strb.oe_n;
    assign mem_we_n   = strb.we_n;
    assign mem_dq_oe  = strb.dq_oe;
    assign rsp_done   = strb.done;
    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;
    assign rsp_data   = rdata_q;
    assign req_ready  = (state == ST_IDLE) && pace_ok;

    // R6: never drive while the memory drives
    a_r6_no_contention: assert property (@(posedge clk) disable iff (rst)
        !(mem_dq_oe && !mem_ce_n && !mem_oe_n && mem_we_n));

    // R6: output enable never falls right after a driven cycle
    a_r6_turnaround: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_oe_n) |-> !$past(mem_dq_oe));

    // R3: drive only inside the strobe or in the cycle right after it
    a_r3_drive_window: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> (!mem_we_n || $past(!mem_we_n)));

    // R2: write strobe always inside chip select, never with output enable
    a_r2_write_overlap: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (!mem_ce_n && mem_oe_n));

    // R5: done lasts one cycle
    a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

    // R7: busy after taking a request
    a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R8: address held while selected
    a_r8_addr_stable: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));
endmodule

// File: tb/test_sram_cyc_ctl.sv
`timescale 1ns/1ps

module sram_model_tb (
    input  logic        clk,
    input  logic        rst,
    input  logic        ce_n,
    input  logic        oe_n,
    input  logic        we_n,
    input  logic [10:0] addr,
    input  logic [7:0]  dq_out,
    input  logic        dq_oe,
    output logic [7:0]  dq_in
);
    logic [7:0] mem [0:2047];
    logic       armed;
    logic       wend;

    initial begin
        for (int i = 0; i < 2048; i++) mem[i] = 8'(i) ^ 8'h5A;
        armed = 1'b0;
    end

    assign wend  = ce_n | we_n;
    assign dq_in = (!ce_n && !oe_n && we_n) ? mem[addr] : 8'hEE;

    always @(negedge clk) if (!rst && !ce_n && !we_n) armed = 1'b1;

    always @(posedge wend) begin
        if (!rst && armed) begin
            mem[addr] = dq_oe ? dq_out : 8'hEE;
            armed = 1'b0;
        end
    end
endmodule

module test_sram_cyc_ctl;
    localparam int P_PWE = 3, P_SD = 2, P_AA = 3, P_TURN = 2, P_MIN = 6;
    // expected counts derived from the requirement text
    localparam int E_WD    = (P_SD > P_PWE - 1) ? P_SD : P_PWE - 1;
    localparam int E_WLAT  = 2 + E_WD;
    localparam int E_RLAT  = P_AA + 1;
    localparam int E_RGAP  = (P_MIN > P_AA + 2) ? P_MIN : P_AA + 2;
    localparam int E_WGAP  = (P_MIN > 3 + E_WD + P_TURN) ? P_MIN : 3 + E_WD + P_TURN;

    logic clk = 1'b0, rst = 1'b1;
    always #2 clk = ~clk;

    logic        req_valid = 0, req_write = 0, req_ready, rsp_done;
    logic [10:0] req_addr = 0, mem_addr;
    logic [7:0]  req_wdata = 0, rsp_data, mem_dq_out, mem_dq_in;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;

    sram_cyc_ctl #(.T_PWE(P_PWE), .T_SD(P_SD), .T_AA(P_AA), .T_TURN(P_TURN),
                   .T_MIN_CYC(P_MIN)) i_sram_cyc_ctl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_data(rsp_data), .rsp_done(rsp_done), .mem_ce_n(mem_ce_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

    sram_model_tb u_mem (.clk(clk), .rst(rst), .ce_n(mem_ce_n), .oe_n(mem_oe_n),
        .we_n(mem_we_n), .addr(mem_addr), .dq_out(mem_dq_out), .dq_oe(mem_dq_oe),
        .dq_in(mem_dq_in));

    // second instance with every interval at zero (R9)
    logic        z_valid = 0, z_write = 0, z_ready, z_done;
    logic [10:0] z_addr = 0, z_maddr;
    logic [7:0]  z_wdata = 0, z_rdata, z_dq_out, z_dq_in;
    logic        z_ce_n, z_oe_n, z_we_n, z_dq_oe;

    sram_cyc_ctl #(.T_PWE(0), .T_SD(0), .T_AA(0), .T_TURN(0), .T_MIN_CYC(0))
    i_sram_cyc_ctl_min (
        .clk(clk), .rst(rst), .req_valid(z_valid), .req_write(z_write),
        .req_addr(z_addr), .req_wdata(z_wdata), .req_ready(z_ready),
        .rsp_data(z_rdata), .rsp_done(z_done), .mem_ce_n(z_ce_n),
        .mem_oe_n(z_oe_n), .mem_we_n(z_we_n), .mem_addr(z_maddr),
        .mem_dq_out(z_dq_out), .mem_dq_oe(z_dq_oe), .mem_dq_in(z_dq_in));

    sram_model_tb u_mem_min (.clk(clk), .rst(rst), .ce_n(z_ce_n), .oe_n(z_oe_n),
        .we_n(z_we_n), .addr(z_maddr), .dq_out(z_dq_out), .dq_oe(z_dq_oe),
        .dq_in(z_dq_in));

    int nchk = 0, nerr = 0, nreq = 0;
    bit finished = 0;

    task automatic check(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_ge(input string tag, input int act, input int lim);
        nchk++;
        if (act < lim) begin
            nerr++;
            $display("FAIL %s actual %0d expected >= %0d", tag, act, lim);
        end
    endtask

    // monitor, sampled 1 ns before each rising edge
    int gap_cnt = 0, last_gap = 0, gap_err = 0, have_prev = 0;
    int contention = 0, wrun = 0, srun = 0, min_wrun = 999, max_wrun = 0, min_srun = 999;
    int drive_err = 0, lead_err = 0, hold_err = 0, since = 100, min_turn = 999;
    int done_cnt = 0, addr_err = 0;
    logic p_wlow = 0, p_oe_n = 1, p_ce_n = 1;
    logic [10:0] p_addr = 0;

    always begin
        @(negedge clk); #1;
        if (!rst) begin
            logic wlow;
            wlow = !mem_ce_n && !mem_we_n;
            gap_cnt++;
            if (req_valid && req_ready) begin
                if (have_prev != 0) begin
                    last_gap = gap_cnt;
                    if (gap_cnt < P_MIN) gap_err++;
                end
                have_prev = 1;
                gap_cnt = 0;
            end
            if (mem_dq_oe && !mem_ce_n && !mem_oe_n && mem_we_n) contention++;
            if (mem_dq_oe && !wlow && !p_wlow) drive_err++;
            if (wlow && !p_wlow && mem_dq_oe) lead_err++;
            if (wlow) begin
                wrun++;
                if (mem_dq_oe) srun++; else srun = 0;
            end else if (p_wlow) begin
                if (wrun < min_wrun) min_wrun = wrun;
                if (wrun > max_wrun) max_wrun = wrun;
                if (srun < min_srun) min_srun = srun;
                if (!mem_dq_oe) hold_err++;
                wrun = 0; srun = 0;
            end
            if (!mem_oe_n && p_oe_n && since < min_turn) min_turn = since;
            if (mem_dq_oe) since = 0; else since++;
            if (rsp_done) done_cnt++;
            if (!mem_ce_n && !p_ce_n && mem_addr != p_addr) addr_err++;
            p_wlow = wlow; p_oe_n = mem_oe_n; p_ce_n = mem_ce_n; p_addr = mem_addr;
        end
    end

    task automatic do_req(input bit w, input logic [10:0] a, input logic [7:0] d,
                          output logic [7:0] rd, output int lat);
        @(negedge clk);
        req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        nreq++;
        check("R7 ready low after accept", int'(req_ready), 0);
        lat = 1;
        while (!rsp_done && lat < 50) begin
            @(negedge clk);
            lat++;
        end
        rd = rsp_data;
    endtask

    task automatic do_req_z(input bit w, input logic [10:0] a, input logic [7:0] d,
                            output logic [7:0] rd, output int lat);
        @(negedge clk);
        z_valid = 1; z_write = w; z_addr = a; z_wdata = d;
        while (!z_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        z_valid = 0;
        lat = 1;
        while (!z_done && lat < 50) begin
            @(negedge clk);
            lat++;
        end
        rd = z_rdata;
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 ce_n in reset", int'(mem_ce_n), 1);
        check("R1 oe_n in reset", int'(mem_oe_n), 1);
        check("R1 we_n in reset", int'(mem_we_n), 1);
        check("R1 dq_oe in reset", int'(mem_dq_oe), 0);
        check("R1 done in reset", int'(rsp_done), 0);
        rst = 0;
        @(negedge clk);
        check("R1 ready after reset", int'(req_ready), 1);
        check("R1 strobes after reset", int'({mem_ce_n, mem_oe_n, mem_we_n}), 7);
    endtask

    task automatic t_write_read;
        logic [7:0] rd; int lat;
        do_req(1, 11'h123, 8'hA5, rd, lat);
        check("R2 write done latency", lat, E_WLAT);
        do_req(0, 11'h123, 8'h00, rd, lat);
        check("R4 read done latency", lat, E_RLAT);
        check("R4 read data", int'(rd), 8'hA5);
        check("R4 strobes high at done", int'({mem_ce_n, mem_oe_n, mem_we_n}), 7);
        do_req(0, 11'h045, 8'h00, rd, lat);
        check("R4 unwritten word", int'(rd), int'(8'h45 ^ 8'h5A));
        do_req(1, 11'h123, 8'h3C, rd, lat);
        do_req(0, 11'h123, 8'h00, rd, lat);
        check("R2 overwrite read", int'(rd), 8'h3C);
    endtask

    task automatic t_extremes;
        logic [7:0] rd; int lat;
        do_req(1, 11'h000, 8'h00, rd, lat);
        do_req(1, 11'h7FF, 8'hFF, rd, lat);
        do_req(0, 11'h000, 8'h00, rd, lat);
        check("R8 address 0", int'(rd), 0);
        do_req(0, 11'h7FF, 8'h00, rd, lat);
        check("R8 address 2047", int'(rd), 8'hFF);
    endtask

    task automatic t_pacing;
        logic [7:0] rd; int lat;
        do_req(0, 11'h010, 8'h00, rd, lat);
        do_req(0, 11'h011, 8'h00, rd, lat);
        check("R7 read to read gap", last_gap, E_RGAP);
        do_req(1, 11'h020, 8'h81, rd, lat);
        do_req(1, 11'h021, 8'h7E, rd, lat);
        check("R7 write to write gap", last_gap, E_WGAP);
        do_req(0, 11'h021, 8'h00, rd, lat);
        check("R6 read right after write", int'(rd), 8'h7E);
    endtask

    task automatic t_zero_params;
        logic [7:0] rd; int lat;
        do_req_z(1, 11'h2AA, 8'hC3, rd, lat);
        check("R9 write latency", lat, 3);
        do_req_z(0, 11'h2AA, 8'h00, rd, lat);
        check("R9 read latency", lat, 2);
        check("R9 read data", int'(rd), 8'hC3);
    endtask

    task automatic t_monitor_totals;
        repeat (4) @(negedge clk);
        check("R6 contention cycles", contention, 0);
        check_ge("R6 turnaround cycles", min_turn, P_TURN);
        check_ge("R2 strobe width", min_wrun, P_PWE);
        check("R2 strobe width exact", max_wrun, 1 + E_WD);
        check_ge("R3 data setup", min_srun, P_SD);
        check("R3 early drive", drive_err + lead_err, 0);
        check("R3 hold after end", hold_err, 0);
        check("R7 min gap violations", gap_err, 0);
        check("R5 done pulses", done_cnt, nreq);
        check("R8 address changes", addr_err, 0);
    endtask

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        t_reset;
        t_write_read;
        t_extremes;
        t_pacing;
        t_zero_params;
        t_monitor_totals;
        finished = 1;
        summary;
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nchk++; nerr++;
            $display("FAIL watchdog actual hung expected completion");
            summary;
            $finish;
        end
    end
endmodule